// File: doc/BRIEF.md
# Sliding-Window Rank-Order Filter

This block keeps the most recent `DEPTH` samples of a stream in ascending order and returns any chosen order statistic of that window. A chain of identical sorting cells holds the window. Each cell stores one sample value, the age of that sample and an occupied flag.

When a sample is accepted, the oldest entry leaves the chain and the new sample goes straight to its sorted slot, all in one clock edge. The list is never sorted again from scratch. Each cell settles its own next state from its two neighbours, a comparison with the incoming sample, and whether the entry being removed lies below it or at its own slot. The cell can hold its entry, take the entry of the cell above, take the entry of the cell below, or load the new sample.

A rank index selects one slot of the ordered window through a combinational multiplexer. Slot 0 gives the minimum, slot `DEPTH-1` gives the maximum, and the middle slots give the median.

Top module: `running_rank_sorter`

## Requirements
- R1: A synchronous active-high reset empties the window, and `out_valid` is low in the cycle after reset.
- R2: `out_valid` stays low until `DEPTH` samples have been accepted since reset. It goes high right after the edge that accepts sample number `DEPTH` and then stays high.
- R3: While `out_valid` is high, `out_sample` equals the element at position `rank_sel` of the last `DEPTH` accepted samples sorted ascending. Position 0 is the smallest and position `DEPTH-1` is the largest.
- R4: A change of `rank_sel` shows on `out_sample` in the same cycle, with no clock edge needed.
- R5: A cycle with `in_valid` low leaves the window unchanged. Every rank reads back the same value afterwards.
- R6: Each accepted sample replaces exactly the oldest entry of the full window. This holds for streams with many repeated values and for rising or falling streams. Among equal values, the newer sample sits above the older one.
- R7: The stored entries are always in non-decreasing order from slot 0 to slot `DEPTH-1`. Occupied slots form one run that starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `in_sample` at this edge |
| in_sample | input | DATA_W | Incoming sample |
| rank_sel | input | $clog2(DEPTH) | Sorted position to read |
| out_sample | output | DATA_W | Value at sorted position `rank_sel` |
| out_valid | output | 1 | Window has been filled since reset |

## Verification
A sample driven with `in_valid` is taken at the next rising edge and is part of the window right after that edge. `out_sample` is purely combinational from the stored window and `rank_sel`, so a new rank is due within the same cycle.

The bench drives each sample for exactly one rising edge and clears `in_valid` before the edge that follows. It then steps `rank_sel` through several values during the low half of the clock, sampling each one a fraction of a nanosecond after setting it. `out_valid` is checked after every one of the first `DEPTH` samples, so a flag that rises one edge early or one edge late is caught.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    // What a sorting cell does with its slot at an accepted sample.
    typedef enum logic [1:0] {
        MV_HOLD    = 2'd0,
        MV_FROM_UP = 2'd1,
        MV_FROM_DN = 2'd2,
        MV_LOAD    = 2'd3
    } pe_move_e;

    localparam int DATA_W_DEF = 8;
    localparam int DEPTH_DEF  = 64;

    // Slot ordering test: an empty slot counts as larger than any sample.
    function automatic logic above_new(input logic used, input logic [31:0] v,
                                       input logic [31:0] x);
        return !used || (v > x);
    endfunction

endpackage

// File: rtl/sort_pe.sv
module sort_pe
    import sorter_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [DW-1:0] din,
    input  logic          del_le,
    input  logic          del_lt,
    input  logic          up_used,
    input  logic [AW-1:0] up_age,
    input  logic [DW-1:0] up_val,
    input  logic          dn_used,
    input  logic [AW-1:0] dn_age,
    input  logic [DW-1:0] dn_val,
    output logic          used_q,
    output logic [AW-1:0] age_q,
    output logic [DW-1:0] val_q
);
    logic          cur_used, prv_used, cur_gt, prv_gt;
    logic [DW-1:0] cur_val, prv_val;
    pe_move_e      mv;

    always_comb begin
        cur_used = del_le ? up_used : used_q;
        cur_val  = del_le ? up_val  : val_q;
        prv_used = del_lt ? used_q  : dn_used;
        prv_val  = del_lt ? val_q   : dn_val;
        prv_gt   = above_new(prv_used, 32'(prv_val), 32'(din));
        cur_gt   = above_new(cur_used, 32'(cur_val), 32'(din));
        if (prv_gt)      mv = del_lt ? MV_HOLD : MV_FROM_DN;
        else if (cur_gt) mv = MV_LOAD;
        else             mv = del_le ? MV_FROM_UP : MV_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= 1'b0;
            age_q  <= '0;
            val_q  <= '0;
        end else if (adv) begin
            unique case (mv)
                MV_HOLD: begin
                    age_q <= used_q ? age_q + 1'b1 : age_q;
                end
                MV_FROM_UP: begin
                    used_q <= up_used;
                    val_q  <= up_val;
                    age_q  <= up_used ? up_age + 1'b1 : '0;
                end
                MV_FROM_DN: begin
                    used_q <= dn_used;
                    val_q  <= dn_val;
                    age_q  <= dn_used ? dn_age + 1'b1 : '0;
                end
                default: begin
                    used_q <= 1'b1;
                    val_q  <= din;
                    age_q  <= '0;
                end
            endcase
        end
    end

    // R6: a loaded slot holds the new sample with age zero
    assert_load_fresh_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && mv == MV_LOAD) |=> (used_q && val_q == $past(din) && age_q == '0));

endmodule

// File: rtl/oldest_locate.sv
module oldest_locate #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DEPTH-1:0]    used,
    input  logic [DEPTH*AW-1:0] ages,
    output logic [DEPTH-1:0]    del_le,
    output logic [DEPTH-1:0]    del_lt,
    output logic                full
);
    logic [DEPTH-1:0] del;

    assign full = used[DEPTH-1];

    for (genvar i = 0; i < DEPTH; i++) begin : g_loc
        if (i == DEPTH - 1) begin : g_top
            assign del[i] = full ? (ages[i*AW +: AW] == AW'(DEPTH - 1)) : 1'b1;
        end else begin : g_mid
            assign del[i] = full && used[i] && (ages[i*AW +: AW] == AW'(DEPTH - 1));
        end
        assign del_le[i] = |del[i:0];
        if (i == 0) begin : g_lo
            assign del_lt[i] = 1'b0;
        end else begin : g_hi
            assign del_lt[i] = |del[i-1:0];
        end
    end

    // R6: exactly one slot is marked for removal
    assert_one_oldest_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot(del));

endmodule

// File: rtl/rank_select.sv
module rank_select #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int RW    = 6
) (
    input  logic [DEPTH*DW-1:0] vals,
    input  logic [RW-1:0]       idx,
    output logic [DW-1:0]       sel
);
    assign sel = vals[idx*DW +: DW];
endmodule

// File: rtl/running_rank_sorter.sv
module running_rank_sorter
    import sorter_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int DEPTH  = DEPTH_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_sample,
    input  logic [$clog2(DEPTH)-1:0] rank_sel,
    output logic [DATA_W-1:0]        out_sample,
    output logic                     out_valid
);
    localparam int RANK_W = $clog2(DEPTH);
    localparam int AGE_W  = RANK_W;

    logic [DEPTH-1:0]        used;
    logic [DEPTH*AGE_W-1:0]  ages;
    logic [DEPTH*DATA_W-1:0] vals;
    logic [DEPTH-1:0]        del_le, del_lt;
    logic                    full;

    oldest_locate #(.DEPTH(DEPTH), .AW(AGE_W)) u_loc (
        .clk(clk), .rst(rst), .used(used), .ages(ages),
        .del_le(del_le), .del_lt(del_lt), .full(full)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic              u_used, d_used;
        logic [AGE_W-1:0]  u_age,  d_age;
        logic [DATA_W-1:0] u_val,  d_val;

        if (i == DEPTH - 1) begin : g_top
            assign u_used = 1'b0;
            assign u_age  = '0;
            assign u_val  = '0;
        end else begin : g_up
            assign u_used = used[i+1];
            assign u_age  = ages[(i+1)*AGE_W +: AGE_W];
            assign u_val  = vals[(i+1)*DATA_W +: DATA_W];
        end
        if (i == 0) begin : g_bot
            assign d_used = 1'b1;
            assign d_age  = '0;
            assign d_val  = '0;
        end else begin : g_dn
            assign d_used = used[i-1];
            assign d_age  = ages[(i-1)*AGE_W +: AGE_W];
            assign d_val  = vals[(i-1)*DATA_W +: DATA_W];
        end

        sort_pe #(.DW(DATA_W), .AW(AGE_W)) u_pe (
            .clk(clk), .rst(rst), .adv(in_valid), .din(in_sample),
            .del_le(del_le[i]), .del_lt(del_lt[i]),
            .up_used(u_used), .up_age(u_age), .up_val(u_val),
            .dn_used(d_used), .dn_age(d_age), .dn_val(d_val),
            .used_q(used[i]), .age_q(ages[i*AGE_W +: AGE_W]),
            .val_q(vals[i*DATA_W +: DATA_W])
        );

        if (i < DEPTH - 1) begin : g_chk
            // R7: neighbouring occupied slots stay in ascending order
            assert_sorted_R7: assert property (@(posedge clk) disable iff (rst)
                (used[i] && used[i+1]) |-> (vals[i*DATA_W +: DATA_W] <= vals[(i+1)*DATA_W +: DATA_W]));
            // R7: occupied slots are contiguous from slot 0
            assert_packed_R7: assert property (@(posedge clk) disable iff (rst)
                used[i+1] |-> used[i]);
        end
    end

    rank_select #(.DW(DATA_W), .DEPTH(DEPTH), .RW(RANK_W)) u_sel (
        .vals(vals), .idx(rank_sel), .sel(out_sample)
    );

    assign out_valid = full;

    // R5: an idle cycle leaves the stored window untouched
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(vals) && $stable(used)));

    // R2: once filled, the window stays filled until reset
    assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

endmodule

// File: tb/sim_running_rank_sorter.sv
`timescale 1ns/1ps
module sim_running_rank_sorter;
    localparam int DW = 8;
    localparam int N  = 64;
    localparam int RW = $clog2(N);

    // Stream segments: {kind[1:0], length[9:0]}
    // kind 0 random, 1 heavy duplicates, 2 rising, 3 falling
    localparam logic [11:0] SEGS [7] = '{
        {2'd0, 10'd80}, {2'd1, 10'd90}, {2'd2, 10'd70}, {2'd3, 10'd70},
        {2'd1, 10'd40}, {2'd0, 10'd60}, {2'd2, 10'd30}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic [RW-1:0] rank_sel = '0;
    logic [DW-1:0] out_sample;
    logic          out_valid;

    int n_run = 0, n_fail = 0;
    int win [N];
    int wcnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    running_rank_sorter #(.DATA_W(DW), .DEPTH(N)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .rank_sel(rank_sel), .out_sample(out_sample), .out_valid(out_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_rank(input int r);
        for (int j = 0; j < N; j++) begin
            int lt = 0, eq = 0;
            for (int k = 0; k < N; k++) begin
                if (win[k] < win[j]) lt++;
                else if (win[k] == win[j]) eq++;
            end
            if (lt <= r && r < lt + eq) return win[j];
        end
        return -1;
    endfunction

    task automatic push(input int s);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = DW'(s);
        @(negedge clk);
        in_valid  = 1'b0;
        for (int j = 0; j < N - 1; j++) win[j] = win[j+1];
        win[N-1] = s;
        if (wcnt < N) wcnt++;
    endtask

    task automatic probe(input string req, input int r);
        rank_sel = RW'(r);
        #0.5;
        check(req, int'(out_sample), ref_rank(r));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wcnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        #0.5;
        check("R1 out_valid after reset", int'(out_valid), 0);

        // Table walk
        for (int s = 0; s < 7; s++) begin
            int kind = int'(SEGS[s][11:10]);
            int len  = int'(SEGS[s][9:0]);
            for (int k = 0; k < len; k++) begin
                int v;
                case (kind)
                    0: v = int'($urandom % 256);
                    1: v = 100 + int'($urandom % 3);
                    2: v = (k * 3) % 256;
                    default: v = 255 - (k * 3) % 256;
                endcase
                push(v);
                #0.5;
                if (wcnt < N) begin
                    check("R2 out_valid before full", int'(out_valid), 0);
                end else begin
                    check("R2 out_valid when full", int'(out_valid), 1);
                    // R3 / R4: several ranks read without a clock edge between them
                    probe("R3 min rank", 0);
                    probe("R3 median low", N/2 - 1);
                    probe("R4 median high", N/2);
                    probe("R3 max rank", N - 1);
                    probe(kind == 1 ? "R6 duplicate stream" : "R6 window slide",
                          int'($urandom % N));
                end
            end
        end

        // R7: full readout is non-decreasing
        for (int r = 0; r < N - 1; r++) begin
            int a, b;
            rank_sel = RW'(r);
            #0.05;
            a = int'(out_sample);
            rank_sel = RW'(r + 1);
            #0.05;
            b = int'(out_sample);
            check("R7 ascending readout", int'(a <= b), 1);
        end

        // R5: idle cycles change nothing
        repeat (6) @(negedge clk);
        probe("R5 idle min", 0);
        probe("R5 idle median", N/2);
        probe("R5 idle max", N - 1);
        probe("R5 idle mid", 17);

        // R1: reset mid-run, then partial refill keeps out_valid low
        do_reset();
        #0.5;
        check("R1 out_valid after second reset", int'(out_valid), 0);
        for (int k = 0; k < N - 1; k++) push(int'($urandom % 256));
        #0.5;
        check("R2 one short of full", int'(out_valid), 0);
        push(7);
        #0.5;
        check("R2 full after last fill sample", int'(out_valid), 1);
        probe("R3 after refill min", 0);
        probe("R3 after refill max", N - 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule